// File: doc/BRIEF.md
# PLL Frequency-Word Update Sequencer

This block runs the handshake that makes a running PLL take in a new integer multiplier and fractional word. A one-cycle request starts the sequence. The block then raises an update strobe toward the PLL and waits a short arming interval before it looks at the PLL's latch acknowledge. Once the acknowledge has come and gone, it waits a settle interval and then reports completion.

There are two ways to end the update strobe, and the mode input picks one when the request is accepted:
- **Self-clearing mode:** the strobe drops by itself as soon as the acknowledge is high, and the sequencer waits until it sees the strobe low.
- **Explicit mode:** the sequencer waits for the acknowledge and then drops the strobe itself.

Both modes then wait for the acknowledge to fall, followed by the settle interval. Every wait is bounded by a poll budget. If the budget runs out, the block abandons the sequence, drops the strobe and flags a timeout.

A request that arrives while the PLL is disabled, or while dynamic update is not permitted, completes at once with no handshake.

Top module: `pll_update_latch`

## Requirements
- R1: During and directly after reset, `updateOut`, `busy`, `done` and `timeoutErr` are all low, and `ackIn` has no effect while idle.
- R2: A request with `pllOn` or `dynEn` low gives a `done` pulse on the next cycle with `busy`, `updateOut` and `timeoutErr` all staying low.
- R3: A request accepted with `pllOn` and `dynEn` both high raises `updateOut` and `busy` on the next cycle.
- R4: The acknowledge is not used to end the strobe in explicit mode until ARM_CYCLES cycles after the strobe rose, so the strobe stays high for at least ARM_CYCLES+1 cycles in that mode.
- R5: In self-clearing mode (`bypassIn` = 0 at acceptance), `updateOut` falls the cycle after `ackIn` is first sampled high. Counting cycles from the rise of `updateOut`, an acknowledge arriving after D cycles gives a strobe width of D+1 cycles.
- R6: In explicit mode (`bypassIn` = 1 at acceptance), `updateOut` is cleared by the sequencer one cycle after it samples `ackIn` high. The strobe width is therefore max(ARM_CYCLES+1, D+1) cycles.
- R7: After the strobe is low, the block waits for `ackIn` to be low. It then counts SETTLE_TICKS poll periods of POLL_CYCLES cycles each and gives a one-cycle `done`, and `busy` is low in that cycle.
- R8: If a wait phase lasts POLL_LIMIT poll periods, `timeoutErr` and `done` pulse together and `updateOut` is low. With no acknowledge at all, the strobe width is ARM_CYCLES + POLL_LIMIT*POLL_CYCLES cycles.
- R9: While `busy` is high, further requests and changes of `bypassIn` have no effect on the running sequence and produce no extra `done`.
- R10: `timeoutErr` is never high without `done`, and each accepted request produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updReq | input | 1 | One-cycle update request |
| pllOn | input | 1 | PLL is enabled and running |
| dynEn | input | 1 | Dynamic update is permitted |
| bypassIn | input | 1 | 1 = explicit strobe clear, 0 = self-clearing strobe; sampled at acceptance |
| ackIn | input | 1 | Latch acknowledge from the PLL |
| updateOut | output | 1 | Update strobe toward the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | One-cycle timeout flag, coincident with `done` |

## Verification
The hardest cases to reach are the ones where the acknowledge comes very early or very late.

An early acknowledge arrives while the arming interval is still running. In self-clearing mode the strobe then drops mid-arm, and the acknowledge may even fall before the sequencer starts watching for it. In explicit mode the same acknowledge has to be held off until arming ends.

The stimulus reaches these cases by drawing the acknowledge delay at random from zero up past the arming interval, in both modes. A bench PLL model answers at that delay and drops the acknowledge a random number of cycles after the strobe falls.

The timeouts are reached with directed runs. One model never acknowledges, in each mode. Another raises the acknowledge and never drops it.

// File: rtl/pll_upd_pkg.sv
package pll_upd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT_SET,
    ST_WAIT_CLR,
    ST_WAIT_FALL,
    ST_SETTLE
  } seqState_t;

  typedef struct packed {
    logic raiseUpd;
    logic dropUpd;
    logic restartTimer;
  } seqStrobe_t;

endpackage

// File: rtl/updlatch_datapath.sv
module updlatch_datapath
  import pll_upd_pkg::*;
#(
  parameter int POLL_CYCLES  = 4,
  parameter int POLL_LIMIT   = 100,
  parameter int SETTLE_TICKS = 10,
  parameter int ARM_CYCLES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       bypassIn,
  input  logic       ackIn,
  output logic       updateOut,
  output logic       modeBypass,
  output logic       armDone,
  output logic       waitExpired,
  output logic       settleDone
);

  localparam int CNT_MAX = (POLL_LIMIT > SETTLE_TICKS) ? POLL_LIMIT : SETTLE_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int ARM_W   = $clog2(ARM_CYCLES + 1);

  logic             updReg;
  logic             modeReg;
  logic [ARM_W-1:0] armCnt;
  logic [CNT_W-1:0] pollCnt;
  logic             pollTick;

  // Update strobe: explicit drop wins, then raise, then self-clear in auto mode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updReg  <= 1'b0;
      modeReg <= 1'b0;
    end else begin
      if (strobe.raiseUpd) modeReg <= bypassIn;
      if (strobe.dropUpd)                     updReg <= 1'b0;
      else if (strobe.raiseUpd)               updReg <= 1'b1;
      else if (!modeReg && ackIn && updReg)   updReg <= 1'b0;
    end
  end

  // Arming interval counter.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restartTimer) armCnt <= '0;
    else if (!armDone)                armCnt <= armCnt + 1'b1;
  end
  assign armDone = (armCnt == ARM_W'(ARM_CYCLES - 1));

  // Poll period divider, restarted at each phase boundary.
  generate
    if (POLL_CYCLES > 1) begin : g_div
      localparam int DIV_W = $clog2(POLL_CYCLES);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strobe.restartTimer) divCnt <= '0;
        else if (pollTick)                divCnt <= '0;
        else                              divCnt <= divCnt + 1'b1;
      end
      assign pollTick = (divCnt == DIV_W'(POLL_CYCLES - 1));
    end else begin : g_nodiv
      assign pollTick = 1'b1;
    end
  endgenerate

  // Poll counter shared by the wait phases and the settle phase.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restartTimer) pollCnt <= '0;
    else if (pollTick)                pollCnt <= pollCnt + 1'b1;
  end

  assign waitExpired = pollTick && (pollCnt == CNT_W'(POLL_LIMIT - 1));
  assign settleDone  = pollTick && (pollCnt == CNT_W'(SETTLE_TICKS - 1));
  assign updateOut   = updReg;
  assign modeBypass  = modeReg;

endmodule

// File: rtl/updlatch_control.sv
module updlatch_control
  import pll_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updReq,
  input  logic       pllOn,
  input  logic       dynEn,
  input  logic       ackIn,
  input  logic       updateOut,
  input  logic       modeBypass,
  input  logic       armDone,
  input  logic       waitExpired,
  input  logic       settleDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr
);

  seqState_t stateQ, stateD;
  logic      doneD, timeoutD;

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    doneD    = 1'b0;
    timeoutD = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (updReq) begin
          if (pllOn && dynEn) begin
            strobe.raiseUpd     = 1'b1;
            strobe.restartTimer = 1'b1;
            stateD              = ST_ARM;
          end else begin
            doneD = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (armDone) begin
          strobe.restartTimer = 1'b1;
          stateD = modeBypass ? ST_WAIT_SET : ST_WAIT_CLR;
        end
      end
      ST_WAIT_SET: begin
        if (ackIn) begin
          strobe.dropUpd      = 1'b1;
          strobe.restartTimer = 1'b1;
          stateD              = ST_WAIT_FALL;
        end else if (waitExpired) begin
          strobe.dropUpd = 1'b1;
          doneD          = 1'b1;
          timeoutD       = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      ST_WAIT_CLR: begin
        if (!updateOut) begin
          strobe.restartTimer = 1'b1;
          stateD              = ST_WAIT_FALL;
        end else if (waitExpired) begin
          strobe.dropUpd = 1'b1;
          doneD          = 1'b1;
          timeoutD       = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      ST_WAIT_FALL: begin
        if (!ackIn) begin
          strobe.restartTimer = 1'b1;
          stateD              = ST_SETTLE;
        end else if (waitExpired) begin
          strobe.dropUpd = 1'b1;
          doneD          = 1'b1;
          timeoutD       = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (settleDone) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      stateQ     <= stateD;
      done       <= doneD;
      timeoutErr <= timeoutD;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/pll_update_latch.sv
module pll_update_latch
  import pll_upd_pkg::*;
#(
  parameter int POLL_CYCLES  = 4,
  parameter int POLL_LIMIT   = 100,
  parameter int SETTLE_TICKS = 10,
  parameter int ARM_CYCLES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic updReq,
  input  logic pllOn,
  input  logic dynEn,
  input  logic bypassIn,
  input  logic ackIn,
  output logic updateOut,
  output logic busy,
  output logic done,
  output logic timeoutErr
);

  seqStrobe_t strobe;
  logic       modeBypass, armDone, waitExpired, settleDone;

  updlatch_datapath #(
    .POLL_CYCLES (POLL_CYCLES),
    .POLL_LIMIT  (POLL_LIMIT),
    .SETTLE_TICKS(SETTLE_TICKS),
    .ARM_CYCLES  (ARM_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bypassIn   (bypassIn),
    .ackIn      (ackIn),
    .updateOut  (updateOut),
    .modeBypass (modeBypass),
    .armDone    (armDone),
    .waitExpired(waitExpired),
    .settleDone (settleDone)
  );

  updlatch_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .updReq     (updReq),
    .pllOn      (pllOn),
    .dynEn      (dynEn),
    .ackIn      (ackIn),
    .updateOut  (updateOut),
    .modeBypass (modeBypass),
    .armDone    (armDone),
    .waitExpired(waitExpired),
    .settleDone (settleDone),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

endmodule

// File: rtl/pll_update_latch_chk.sv
module pll_update_latch_chk (
  input logic clk,
  input logic rstN,
  input logic updReq,
  input logic pllOn,
  input logic dynEn,
  input logic bypassIn,
  input logic ackIn,
  input logic updateOut,
  input logic busy,
  input logic done,
  input logic timeoutErr
);

  logic shadowBypass;

  always_ff @(posedge clk) begin
    if (!rstN) shadowBypass <= 1'b0;
    else if (updReq && !busy && pllOn && dynEn) shadowBypass <= bypassIn;
  end

  a_r3_start_raises: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && !busy && pllOn && dynEn) |=> (updateOut && busy));

  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && !busy && !(pllOn && dynEn)) |=> (done && !updateOut && !busy && !timeoutErr));

  a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busy && updateOut && ackIn && !shadowBypass) |=> !updateOut);

  a_r6_bypass_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && updateOut && !ackIn && shadowBypass) |=> (updateOut || done));

  a_r7_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_timeout_drops: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !updateOut);

  a_r10_timeout_with_done: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done);

endmodule

bind pll_update_latch pll_update_latch_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updReq    (updReq),
  .pllOn     (pllOn),
  .dynEn     (dynEn),
  .bypassIn  (bypassIn),
  .ackIn     (ackIn),
  .updateOut (updateOut),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr)
);

// File: tb/tb_pll_update_latch.sv
`timescale 1ns/1ps
module tb_pll_update_latch;

  localparam int P = 4;
  localparam int L = 100;
  localparam int S = 10;
  localparam int A = 2;

  logic clk = 1'b0;
  logic rstN, updReq, pllOn, dynEn, bypassIn, ackIn;
  logic updateOut, busy, done, timeoutErr;
  int   checks = 0;
  int   fails  = 0;

  always #2.5 clk = ~clk;

  pll_update_latch #(.POLL_CYCLES(P), .POLL_LIMIT(L), .SETTLE_TICKS(S), .ARM_CYCLES(A)) dut (
    .clk(clk), .rstN(rstN), .updReq(updReq), .pllOn(pllOn), .dynEn(dynEn),
    .bypassIn(bypassIn), .ackIn(ackIn), .updateOut(updateOut), .busy(busy),
    .done(done), .timeoutErr(timeoutErr));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expWidth(input bit byp, input int d);
    if (!byp) return d + 1;
    return ((A + 1) > (d + 1)) ? (A + 1) : (d + 1);
  endfunction

  // One full handshake with an inline PLL model; sampled at negedges.
  task automatic runTrial(input bit byp, input int d, input int h, input bit never,
                          input bit stuck, input bit poke,
                          output int upDur, output int settleDur, output int doneCnt,
                          output int toCnt, output int busyStart, output int extraDone);
    int upCnt = 0, lowCnt = 0, fallN = 0;
    bit raised = 0, fell = 0;
    upDur = 0; settleDur = 0; doneCnt = 0; toCnt = 0; extraDone = 0;
    @(negedge clk);
    bypassIn = byp; updReq = 1'b1; ackIn = 1'b0;
    @(negedge clk);
    updReq = 1'b0;
    busyStart = busy;
    for (int n = 1; n < 3000; n++) begin
      if (poke && n == 1) begin bypassIn = ~byp; updReq = 1'b1; end
      if (poke && n == 2) updReq = 1'b0;
      if (updateOut) begin
        upCnt++;
        upDur++;
        if (!never && upCnt > d) begin ackIn = 1'b1; raised = 1; end
      end
      if (raised && !updateOut && !fell) begin
        lowCnt++;
        if (!stuck && lowCnt > h) begin ackIn = 1'b0; fell = 1; fallN = n; end
      end
      if (done) begin
        doneCnt++;
        toCnt = timeoutErr;
        settleDur = n - fallN;
        break;
      end
      @(negedge clk);
    end
    ackIn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) extraDone++;
    end
  endtask

  int  upDur, settleDur, doneCnt, toCnt, busyStart, extraDone;
  bit  byp;
  int  d, h;

  initial begin
    rstN = 1'b0; updReq = 1'b0; pllOn = 1'b1; dynEn = 1'b1; bypassIn = 1'b0; ackIn = 1'b0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(!updateOut && !busy && !done && !timeoutErr, "R1", "outputs in reset",
          {updateOut, busy, done, timeoutErr}, 0);
    rstN = 1'b1;
    ackIn = 1'b1;
    repeat (3) @(negedge clk);
    check(!updateOut && !busy && !done && !timeoutErr, "R1", "idle with stray ack",
          {updateOut, busy, done, timeoutErr}, 0);
    ackIn = 1'b0;

    // R2: skip when PLL off, then when dynamic update not permitted.
    for (int s = 0; s < 2; s++) begin
      pllOn = (s == 1); dynEn = (s == 0);
      @(negedge clk); updReq = 1'b1;
      @(negedge clk); updReq = 1'b0;
      check(done && !busy && !updateOut && !timeoutErr, "R2", "skip completes at once",
            {done, busy, updateOut, timeoutErr}, 8);
      @(negedge clk);
      check(!done && !busy && !updateOut, "R2", "skip stays quiet", {done, busy, updateOut}, 0);
    end
    pllOn = 1'b1; dynEn = 1'b1;

    // Directed corners: acknowledge at once in both modes.
    for (int m = 0; m < 2; m++) begin
      runTrial(m[0], 0, 1, 0, 0, 0, upDur, settleDur, doneCnt, toCnt, busyStart, extraDone);
      check(upDur == expWidth(m[0], 0), m ? "R4" : "R5", "strobe width early ack", upDur, expWidth(m[0], 0));
      check(doneCnt == 1 && toCnt == 0, "R10", "single clean done", doneCnt * 10 + toCnt, 10);
    end

    // Randomized handshakes.
    for (int t = 0; t < 30; t++) begin
      byp = $urandom % 2;
      d   = $urandom % 9;
      h   = 1 + $urandom % 5;
      runTrial(byp, d, h, 0, 0, 0, upDur, settleDur, doneCnt, toCnt, busyStart, extraDone);
      check(busyStart == 1, "R3", "busy after accept", busyStart, 1);
      check(upDur == expWidth(byp, d), byp ? "R6" : "R5", "strobe width", upDur, expWidth(byp, d));
      check(settleDur >= S * P + 1 && settleDur <= S * P + A + 3, "R7", "settle length", settleDur, S * P + 1);
      check(doneCnt == 1 && toCnt == 0 && extraDone == 0, "R10", "one done no timeout",
            doneCnt * 100 + toCnt * 10 + extraDone, 100);
    end

    // R9: mode flip and second request while busy are ignored.
    runTrial(1'b1, 0, 2, 0, 0, 1, upDur, settleDur, doneCnt, toCnt, busyStart, extraDone);
    check(upDur == expWidth(1'b1, 0), "R9", "mode held through sequence", upDur, expWidth(1'b1, 0));
    check(doneCnt == 1 && extraDone == 0, "R9", "no extra done", doneCnt * 10 + extraDone, 10);

    // R8: timeouts.
    for (int m = 0; m < 2; m++) begin
      runTrial(m[0], 0, 1, 1, 0, 0, upDur, settleDur, doneCnt, toCnt, busyStart, extraDone);
      check(toCnt == 1 && doneCnt == 1, "R8", "no-ack timeout flagged", toCnt, 1);
      check(upDur == A + L * P, "R8", "no-ack strobe width", upDur, A + L * P);
    end
    runTrial(1'b0, 3, 1, 0, 1, 0, upDur, settleDur, doneCnt, toCnt, busyStart, extraDone);
    check(toCnt == 1 && doneCnt == 1 && !updateOut, "R8", "stuck ack timeout", toCnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule